// File: doc/BRIEF.md
# Consecutive Overcurrent Fault Counter

This block guards a synchronous buck power stage against sustained overload. Once per switching cycle, at the end of each low-side conduction interval, it samples an overcurrent comparator flag. The flag is high when the switch-node voltage sat below the programmed trip level while the low-side switch conducted. Trips on consecutive cycles raise a run count. A single clean cycle sets that count back to zero.

When the run reaches the configured limit (seven by default), the block latches a fault. The fault output stops the PWM logic and turns both the high-side and low-side gates off. From then on the block ignores all sampling activity. Only a power-on reset clears the fault. The current run count is brought out so the surrounding logic and test can observe it.

Top module: `ocp_fault_counter`

## Requirements
- R1: While `rst_ni` is low, `fault_o` is 0 and `trip_cnt_o` is 0.
- R2: A sample is taken on a rising edge of `ls_end_i`, meaning `ls_end_i` is 1 in a clock cycle where it was 0 in the previous cycle. If `oc_trip_i` is 1 in that cycle and no fault is latched, `trip_cnt_o` is one higher after the next clock edge.
- R3: A sample taken with `oc_trip_i` at 0 sets `trip_cnt_o` to 0 after the next clock edge. A run of six trips, then one clean sample, then six more trips therefore produces no fault.
- R4: `oc_trip_i` is ignored when there is no rising edge of `ls_end_i`. Holding `ls_end_i` high for several cycles yields only one sample.
- R5: The sample that brings the count to TRIP_LIMIT (7) sets `fault_o` to 1 on the same clock edge at which `trip_cnt_o` becomes 7.
- R6: Once `fault_o` is 1, it stays 1 and `trip_cnt_o` stays at 7 whatever `ls_end_i` and `oc_trip_i` do, until reset.
- R7: Asserting `rst_ni` low after a fault clears both `fault_o` and `trip_cnt_o` to 0.
- R8: `trip_cnt_o` never exceeds TRIP_LIMIT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| ls_end_i | input | 1 | High at the end of each low-side conduction interval; its rising edge is the sample point |
| oc_trip_i | input | 1 | Comparator flag: 1 when the switch node is below the trip voltage |
| fault_o | output | 1 | Latched fault; 1 forces PWM off and both gates off |
| trip_cnt_o | output | CNT_W (3) | Current count of consecutive trips |

## Verification
The bench targets several corner cases.

- **Run reset:** a run of six trips is broken by one clean cycle and then followed by six more trips. A counter that does not clear on a clean sample would fault here.
- **Held strobe:** the strobe is held high for several cycles with the flag high. A design that samples on level instead of edge would count once per clock.
- **Limit boundary:** the count is checked at six and at seven. An off-by-one limit would latch one sample early or one sample late.
- **Post-fault behaviour:** strobes keep arriving after the fault latches. A design that kept counting would wrap the counter or drop the fault.
- **Reset recovery:** a reset is applied after the fault. A latch that did not clear would leave the stage disabled.

// File: rtl/ocp_fault_pkg.sv
package ocp_fault_pkg;
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_TRIP  = 2'd1,
    EV_CLEAN = 2'd2
  } oc_evt_e;
endpackage

// File: rtl/ocp_sample_edge.sv
module ocp_sample_edge
  import ocp_fault_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    ls_end_i,
  input  logic    oc_trip_i,
  input  logic    block_i,
  output logic    strobe_q_o,
  output oc_evt_e evt_o
);
  logic strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= ls_end_i;
  end

  always_comb begin
    evt_o = EV_NONE;
    if (!block_i && ls_end_i && !strobe_q)
      evt_o = oc_trip_i ? EV_TRIP : EV_CLEAN;
  end

  assign strobe_q_o = strobe_q;
endmodule

// File: rtl/ocp_run_counter.sv
module ocp_run_counter
  import ocp_fault_pkg::*;
#(
  parameter int TRIP_LIMIT = 7,
  parameter int CNT_W      = $clog2(TRIP_LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  oc_evt_e          evt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             reach_o
);
  localparam logic [CNT_W-1:0] LimitC = CNT_W'(TRIP_LIMIT);
  localparam logic [CNT_W-1:0] PreC   = CNT_W'(TRIP_LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      unique case (evt_i)
        EV_TRIP:  if (cnt_q < LimitC) cnt_q <= cnt_q + 1'b1;
        EV_CLEAN: cnt_q <= '0;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  // this sample completes the run
  assign reach_o = (evt_i == EV_TRIP) && (cnt_q == PreC);
  assign cnt_o   = cnt_q;

  p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LimitC);
  p_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i == EV_TRIP) && (cnt_q < LimitC) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  p_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i == EV_CLEAN) |=> cnt_q == '0);
endmodule

// File: rtl/ocp_fault_latch.sv
module ocp_fault_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  output logic fault_o
);
  logic fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    fault_q <= 1'b0;
    else if (set_i) fault_q <= 1'b1;
  end

  assign fault_o = fault_q;

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_q |=> fault_q);
endmodule

// File: rtl/ocp_fault_counter.sv
module ocp_fault_counter
  import ocp_fault_pkg::*;
#(
  parameter int TRIP_LIMIT = 7,
  parameter int CNT_W      = $clog2(TRIP_LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ls_end_i,
  input  logic             oc_trip_i,
  output logic             fault_o,
  output logic [CNT_W-1:0] trip_cnt_o
);
  localparam logic [CNT_W-1:0] LimitC = CNT_W'(TRIP_LIMIT);

  oc_evt_e evt;
  logic    strobe_q;
  logic    reach;
  logic    fault;

  ocp_sample_edge u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ls_end_i   (ls_end_i),
    .oc_trip_i  (oc_trip_i),
    .block_i    (fault),
    .strobe_q_o (strobe_q),
    .evt_o      (evt)
  );

  ocp_run_counter #(.TRIP_LIMIT(TRIP_LIMIT), .CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .cnt_o   (trip_cnt_o),
    .reach_o (reach)
  );

  ocp_fault_latch u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (reach),
    .fault_o (fault)
  );

  assign fault_o = fault;

  p_fault_at_limit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_cnt_o == LimitC) == fault_o);
  p_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> $stable(trip_cnt_o));
  p_held_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_q && ls_end_i |=> $stable(trip_cnt_o));
endmodule

// File: tb/sim_ocp_fault_counter.sv
`timescale 1ns/1ps
module sim_ocp_fault_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ls_end = 1'b0;
  logic trip = 1'b0;
  logic fault;
  logic [2:0] cnt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  int m_cnt = 0;
  bit m_fault = 1'b0;
  bit m_prev = 1'b0;

  always #5 clk = ~clk;

  ocp_fault_counter u0 (
    .clk_i(clk), .rst_ni(rst_n), .ls_end_i(ls_end), .oc_trip_i(trip),
    .fault_o(fault), .trip_cnt_o(cnt)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_fault = 1'b0; m_prev = 1'b0;
    end else begin
      if (!m_fault && ls_end && !m_prev) begin
        if (trip) begin
          m_cnt = m_cnt + 1;
          if (m_cnt >= 7) begin m_cnt = 7; m_fault = 1'b1; end
        end else begin
          m_cnt = 0;
        end
      end
      m_prev = ls_end;
    end
  end

  // per-cycle model comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (cnt !== 3'(m_cnt) || fault !== m_fault) begin
        errors++;
        $display("FAIL R2 R3 R5 R6 model: cnt=%0d fault=%0b expected cnt=%0d fault=%0b",
                 cnt, fault, m_cnt, m_fault);
      end
      checks++;
      if (int'(cnt) > 7) begin
        errors++;
        $display("FAIL R8 bound: cnt=%0d expected <=7", cnt);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input bit t);
    @(negedge clk); ls_end = 1'b1; trip = t;
    @(negedge clk); ls_end = 1'b0; trip = ~t;
  endtask

  task automatic pulses(input int n, input bit t);
    for (int i = 0; i < n; i++) pulse(t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cnt in reset", int'(cnt), 0);
    chk("R1 fault in reset", int'(fault), 0);
    rst_n = 1'b1;

    pulses(3, 1'b1);
    chk("R2 three trips", int'(cnt), 3);
    pulse(1'b0);
    chk("R3 clean sample", int'(cnt), 0);

    pulses(2, 1'b1);
    // R4: comparator toggles with no strobe edge
    for (int i = 0; i < 6; i++) begin @(negedge clk); trip = ~trip; end
    @(negedge clk);
    chk("R4 no strobe", int'(cnt), 2);
    // R4: strobe held high several cycles
    @(negedge clk); ls_end = 1'b1; trip = 1'b1;
    repeat (5) @(negedge clk);
    ls_end = 1'b0;
    @(negedge clk);
    chk("R4 held strobe", int'(cnt), 3);

    pulse(1'b0);
    pulses(6, 1'b1);
    chk("R3 six trips cnt", int'(cnt), 6);
    pulse(1'b0);
    pulses(6, 1'b1);
    chk("R3 broken run no fault", int'(fault), 0);
    chk("R5 cnt at six", int'(cnt), 6);
    pulse(1'b1);
    chk("R5 fault at seven", int'(fault), 1);
    chk("R5 cnt at seven", int'(cnt), 7);

    pulses(3, 1'b1);
    pulses(2, 1'b0);
    chk("R6 fault sticky", int'(fault), 1);
    chk("R6 cnt frozen", int'(cnt), 7);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R7 fault cleared", int'(fault), 0);
    chk("R7 cnt cleared", int'(cnt), 0);
    rst_n = 1'b1;

    pulses(7, 1'b1);
    chk("R5 second fault", int'(fault), 1);
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    done = 1'b1;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule